// File: doc/BRIEF.md
# Interrupt Event History Buffer

This block keeps a running trace of interrupt activity next to an interrupt controller. It watches the vector of pending request bits and notes, for every source, the cycle in which that bit last went from low to high, and it counts those rising edges per source. Whenever the resolver takes an interrupt, the block writes a record into a small ring: the source number, the cycle of the take and the most recent raise cycle of that source. A grand total counts every take and every direct software raise.

Debug software, or a trace unit, reads the ring through an indexed port. Index 0 is the most recent record, and larger indices go further back in time. Each answer arrives one cycle after the request and includes the latency of that record (take minus raise) and the distance in cycles to the next newer record. Each source also has a two-bit stop setting. When an event matches that setting, the block pulses a halt request for an external debug unit.

Top module: `irq_history`

## Requirements
- R1: When bit s of `pendVec` is high in a cycle after being low in the previous cycle, the current `cycleNow` is stored as the raise time of source s. The per-source raise count of s increments by one and wraps at its width. It is read combinationally on `cntOut` for the source selected by `cntSel`.
- R2: A cycle with `takeValid` high writes one ring record: the source `takeId`, the current `cycleNow` as its take time, and the stored raise time of that source.
- R3: The ring write slot advances by one after every record and returns to slot 0 after slot DEPTH-1, so the oldest record is overwritten once DEPTH records exist.
- R4: A cycle with `rdEn` high loads the read outputs at the next edge, using record number `rdIdx`. Number 0 is the newest record, and number i lies i records further back. While `rdEn` is low, the read outputs hold.
- R5: A record whose take time is zero is empty. Reading it gives `rdValid` low, and all read data fields are zero.
- R6: `rdLatency` equals the take time of the record read minus its raise time.
- R7: `rdGap` equals the take time of the next newer record minus the take time of the record read, and it is 0 for index 0.
- R8: Reset empties every record, sets the write slot to 0, and clears all raise times, raise counts, stop settings, the total and the read outputs.
- R9: `totalRaised` goes up by one for each cycle with `takeValid` and by one for each cycle with `directRaise`, so it goes up by two when both are high.
- R10: The stop setting of a source is written through `modeWe`/`modeSrc`/`modeVal`. Bit 0 means halt on raise and bit 1 means halt on take. `haltReq` is high for one cycle, in the cycle after a matching raise or take.
- R11: If a source rises in the same cycle in which it is taken, the record uses the current cycle as its raise time, so its latency is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cycleNow | input | CYC_W | Free-running cycle count |
| pendVec | input | NUM_SRC | Pending request bits, one per source |
| directRaise | input | 1 | Direct software raise event |
| takeValid | input | 1 | Resolver takes an interrupt this cycle |
| takeId | input | ID_W | Source being taken |
| modeWe | input | 1 | Write strobe for a stop setting |
| modeSrc | input | ID_W | Source whose stop setting is written |
| modeVal | input | 2 | New stop setting (bit0 raise, bit1 take) |
| rdEn | input | 1 | Read request |
| rdIdx | input | IDX_W | Record number, 0 = newest |
| rdValid | output | 1 | Record read holds data |
| rdId | output | ID_W | Source of the record |
| rdTaken | output | CYC_W | Take time |
| rdRaised | output | CYC_W | Raise time |
| rdLatency | output | CYC_W | Take minus raise |
| rdGap | output | CYC_W | Newer take minus this take |
| cntSel | input | ID_W | Source selected for `cntOut` |
| cntOut | output | CNT_W | Raise count of the selected source |
| totalRaised | output | TOT_W | Total of takes and direct raises |
| haltReq | output | 1 | Debug halt request pulse |

## Verification
A write slot that is off by one, or that wraps at the wrong point, moves the whole history. The next read of index 0 then returns the wrong source or the wrong take time, so the fault shows within two cycles of the first take that follows it. A stale or missed raise time shows up in `rdRaised` and `rdLatency` on the first readout of the affected record. A wrong edge detector shows up one cycle sooner, in `cntOut` and `haltReq`. The bench runs a behavioural model in step with the design and compares every output on every clock. Because of that, any drift in the ring or in the counters is caught on the cycle in which it first reaches a port.

// File: rtl/irq_hist_pkg.sv
package irq_hist_pkg;

  // Stop setting of one source: bit 0 halts on raise, bit 1 halts on take.
  typedef enum logic [1:0] {
    STOP_OFF      = 2'b00,
    STOP_ON_RAISE = 2'b01,
    STOP_ON_TAKE  = 2'b10,
    STOP_ON_BOTH  = 2'b11
  } stopMode_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic       wrEntry;  // write a ring record this cycle
    logic       rdLoad;   // load the read outputs
    logic [1:0] totInc;   // amount added to the grand total
  } histStrobe_t;

endpackage

// File: rtl/irq_hist_ctrl.sv
module irq_hist_ctrl
  import irq_hist_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int ID_W    = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] pendVec,
  input  logic               directRaise,
  input  logic               takeValid,
  input  logic [ID_W-1:0]    takeId,
  input  logic               modeWe,
  input  logic [ID_W-1:0]    modeSrc,
  input  logic [1:0]         modeVal,
  input  logic               rdEn,
  output logic [NUM_SRC-1:0] riseVec,
  output histStrobe_t        strobe,
  output logic               haltReq
);

  logic [NUM_SRC-1:0] pendPrev;
  stopMode_e          modeTab [NUM_SRC];
  logic [NUM_SRC-1:0] raiseHalt;
  logic               takeOk;
  logic               takeHalt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendPrev <= '0;
    else       pendPrev <= pendVec;
  end

  assign riseVec = pendVec & ~pendPrev;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        modeTab[s] <= STOP_OFF;
      end else if (modeWe && int'(modeSrc) == s) begin
        modeTab[s] <= stopMode_e'(modeVal);
      end
    end
    assign raiseHalt[s] = riseVec[s] &&
                          (modeTab[s] inside {STOP_ON_RAISE, STOP_ON_BOTH});
  end

  assign takeOk = takeValid && (int'(takeId) < NUM_SRC);

  always_comb begin
    takeHalt = 1'b0;
    if (takeOk) begin
      takeHalt = modeTab[takeId] inside {STOP_ON_TAKE, STOP_ON_BOTH};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) haltReq <= 1'b0;
    else       haltReq <= (|raiseHalt) || takeHalt;
  end

  always_comb begin
    strobe.wrEntry = takeOk;
    strobe.rdLoad  = rdEn;
    strobe.totInc  = {1'b0, takeOk} + {1'b0, directRaise};
  end

endmodule

// File: rtl/irq_hist_data.sv
module irq_hist_data
  import irq_hist_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int DEPTH   = 16,
  parameter int CYC_W   = 32,
  parameter int CNT_W   = 16,
  parameter int TOT_W   = 32,
  parameter int ID_W    = 3,
  parameter int IDX_W   = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [CYC_W-1:0]   cycleNow,
  input  logic [NUM_SRC-1:0] riseVec,
  input  histStrobe_t        strobe,
  input  logic [ID_W-1:0]    takeId,
  input  logic [IDX_W-1:0]   rdIdx,
  input  logic [ID_W-1:0]    cntSel,
  output logic               rdValid,
  output logic [ID_W-1:0]    rdId,
  output logic [CYC_W-1:0]   rdTaken,
  output logic [CYC_W-1:0]   rdRaised,
  output logic [CYC_W-1:0]   rdLatency,
  output logic [CYC_W-1:0]   rdGap,
  output logic [CNT_W-1:0]   cntOut,
  output logic [TOT_W-1:0]   totalRaised
);

  localparam int PTR_W = IDX_W;

  logic [CYC_W-1:0] raisedAt [NUM_SRC];
  logic [CNT_W-1:0] raiseCnt [NUM_SRC];
  logic [ID_W-1:0]  entId    [DEPTH];
  logic [CYC_W-1:0] entTaken [DEPTH];
  logic [CYC_W-1:0] entRaised[DEPTH];
  logic [PTR_W-1:0] wrPtr;
  logic [CYC_W-1:0] raiseSel;
  logic [PTR_W-1:0] slotCur;
  logic [PTR_W-1:0] slotNew;
  logic             idxOk;
  logic             hitValid;

  // Slot that lies 'back' records behind the write slot, modulo DEPTH.
  function automatic logic [PTR_W-1:0] ringSlot(input logic [PTR_W-1:0] wp,
                                                input int back);
    int t;
    t = int'(wp) - back;
    if (t < 0) t = t + DEPTH;
    return t[PTR_W-1:0];
  endfunction

  // Per-source raise time and raise count.
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        raisedAt[s] <= '0;
        raiseCnt[s] <= '0;
      end else if (riseVec[s]) begin
        raisedAt[s] <= cycleNow;
        raiseCnt[s] <= raiseCnt[s] + 1'b1;
      end
    end
  end

  // A same-cycle raise of the taken source forwards the current cycle.
  always_comb begin
    raiseSel = '0;
    if (int'(takeId) < NUM_SRC) begin
      raiseSel = riseVec[takeId] ? cycleNow : raisedAt[takeId];
    end
  end

  // Ring records.
  for (genvar d = 0; d < DEPTH; d++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        entId[d]     <= '0;
        entTaken[d]  <= '0;
        entRaised[d] <= '0;
      end else if (strobe.wrEntry && int'(wrPtr) == d) begin
        entId[d]     <= takeId;
        entTaken[d]  <= cycleNow;
        entRaised[d] <= raiseSel;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
    end else if (strobe.wrEntry) begin
      if (int'(wrPtr) == DEPTH - 1) wrPtr <= '0;
      else                          wrPtr <= wrPtr + 1'b1;
    end
  end

  // Readout, newest first.
  assign idxOk    = int'(rdIdx) < DEPTH;
  assign slotCur  = ringSlot(wrPtr, int'(rdIdx) + 1);
  assign slotNew  = ringSlot(wrPtr, int'(rdIdx));
  assign hitValid = idxOk && (entTaken[slotCur] != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid   <= 1'b0;
      rdId      <= '0;
      rdTaken   <= '0;
      rdRaised  <= '0;
      rdLatency <= '0;
      rdGap     <= '0;
    end else if (strobe.rdLoad) begin
      rdValid <= hitValid;
      if (hitValid) begin
        rdId      <= entId[slotCur];
        rdTaken   <= entTaken[slotCur];
        rdRaised  <= entRaised[slotCur];
        rdLatency <= entTaken[slotCur] - entRaised[slotCur];
        rdGap     <= (rdIdx == '0) ? '0 : (entTaken[slotNew] - entTaken[slotCur]);
      end else begin
        rdId      <= '0;
        rdTaken   <= '0;
        rdRaised  <= '0;
        rdLatency <= '0;
        rdGap     <= '0;
      end
    end
  end

  always_comb begin
    cntOut = '0;
    if (int'(cntSel) < NUM_SRC) cntOut = raiseCnt[cntSel];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) totalRaised <= '0;
    else       totalRaised <= totalRaised + TOT_W'(strobe.totInc);
  end

endmodule

// File: rtl/irq_history.sv
module irq_history
  import irq_hist_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int DEPTH   = 16,
  parameter int CYC_W   = 32,
  parameter int CNT_W   = 16,
  parameter int TOT_W   = 32,
  localparam int ID_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [CYC_W-1:0]   cycleNow,
  input  logic [NUM_SRC-1:0] pendVec,
  input  logic               directRaise,
  input  logic               takeValid,
  input  logic [ID_W-1:0]    takeId,
  input  logic               modeWe,
  input  logic [ID_W-1:0]    modeSrc,
  input  logic [1:0]         modeVal,
  input  logic               rdEn,
  input  logic [IDX_W-1:0]   rdIdx,
  output logic               rdValid,
  output logic [ID_W-1:0]    rdId,
  output logic [CYC_W-1:0]   rdTaken,
  output logic [CYC_W-1:0]   rdRaised,
  output logic [CYC_W-1:0]   rdLatency,
  output logic [CYC_W-1:0]   rdGap,
  input  logic [ID_W-1:0]    cntSel,
  output logic [CNT_W-1:0]   cntOut,
  output logic [TOT_W-1:0]   totalRaised,
  output logic               haltReq
);

  logic [NUM_SRC-1:0] riseVec;
  histStrobe_t        strobe;

  irq_hist_ctrl #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .pendVec(pendVec), .directRaise(directRaise),
    .takeValid(takeValid), .takeId(takeId), .modeWe(modeWe),
    .modeSrc(modeSrc), .modeVal(modeVal), .rdEn(rdEn),
    .riseVec(riseVec), .strobe(strobe), .haltReq(haltReq)
  );

  irq_hist_data #(
    .NUM_SRC(NUM_SRC), .DEPTH(DEPTH), .CYC_W(CYC_W), .CNT_W(CNT_W),
    .TOT_W(TOT_W), .ID_W(ID_W), .IDX_W(IDX_W)
  ) u_data (
    .clk(clk), .rstN(rstN), .cycleNow(cycleNow), .riseVec(riseVec),
    .strobe(strobe), .takeId(takeId), .rdIdx(rdIdx), .cntSel(cntSel),
    .rdValid(rdValid), .rdId(rdId), .rdTaken(rdTaken), .rdRaised(rdRaised),
    .rdLatency(rdLatency), .rdGap(rdGap), .cntOut(cntOut),
    .totalRaised(totalRaised)
  );

endmodule

// File: rtl/irq_history_chk.sv
module irq_history_chk #(
  parameter int NUM_SRC = 8,
  parameter int DEPTH   = 16,
  parameter int CYC_W   = 32,
  parameter int CNT_W   = 16,
  parameter int TOT_W   = 32,
  parameter int ID_W    = 3,
  parameter int IDX_W   = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic [CYC_W-1:0]   cycleNow,
  input logic [NUM_SRC-1:0] pendVec,
  input logic               directRaise,
  input logic               takeValid,
  input logic [ID_W-1:0]    takeId,
  input logic               modeWe,
  input logic [ID_W-1:0]    modeSrc,
  input logic [1:0]         modeVal,
  input logic               rdEn,
  input logic [IDX_W-1:0]   rdIdx,
  input logic               rdValid,
  input logic [ID_W-1:0]    rdId,
  input logic [CYC_W-1:0]   rdTaken,
  input logic [CYC_W-1:0]   rdRaised,
  input logic [CYC_W-1:0]   rdLatency,
  input logic [CYC_W-1:0]   rdGap,
  input logic [ID_W-1:0]    cntSel,
  input logic [CNT_W-1:0]   cntOut,
  input logic [TOT_W-1:0]   totalRaised,
  input logic               haltReq
);

  assert_total_take_R9: assert property (@(posedge clk) disable iff (!rstN)
    (takeValid && !directRaise) |=> totalRaised == $past(totalRaised) + 1'b1);

  assert_total_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!takeValid && !directRaise) |=> $stable(totalRaised));

  assert_read_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> ($stable(rdValid) && $stable(rdTaken) && $stable(rdGap)));

  assert_valid_nonzero_R5: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> rdTaken != '0);

  assert_gap_first_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && rdIdx == '0) |=> rdGap == '0);

  assert_halt_cause_R10: assert property (@(posedge clk) disable iff (!rstN)
    haltReq |-> ($past(takeValid) || $past(|pendVec)));

endmodule

bind irq_history irq_history_chk #(
  .NUM_SRC(NUM_SRC), .DEPTH(DEPTH), .CYC_W(CYC_W), .CNT_W(CNT_W),
  .TOT_W(TOT_W), .ID_W(ID_W), .IDX_W(IDX_W)
) u_chk (.*);

// File: tb/sim_irq_history.sv
`timescale 1ns/1ps
module sim_irq_history;

  localparam int NS = 8;
  localparam int D  = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] cyc = 32'd1;
  logic [7:0]  pendVec = '0;
  logic        directRaise = 1'b0, takeValid = 1'b0, modeWe = 1'b0, rdEn = 1'b0;
  logic [2:0]  takeId = '0, modeSrc = '0, cntSel = '0;
  logic [1:0]  modeVal = '0;
  logic [3:0]  rdIdx = '0;
  logic        rdValid, haltReq;
  logic [2:0]  rdId;
  logic [31:0] rdTaken, rdRaised, rdLatency, rdGap, totalRaised;
  logic [15:0] cntOut;

  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;  // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  irq_history u0 (
    .clk(clk), .rstN(rstN), .cycleNow(cyc), .pendVec(pendVec),
    .directRaise(directRaise), .takeValid(takeValid), .takeId(takeId),
    .modeWe(modeWe), .modeSrc(modeSrc), .modeVal(modeVal), .rdEn(rdEn),
    .rdIdx(rdIdx), .rdValid(rdValid), .rdId(rdId), .rdTaken(rdTaken),
    .rdRaised(rdRaised), .rdLatency(rdLatency), .rdGap(rdGap),
    .cntSel(cntSel), .cntOut(cntOut), .totalRaised(totalRaised),
    .haltReq(haltReq)
  );

  // Behavioural reference model
  logic [31:0] mTaken[D], mRaised[D];
  int          mId[D];
  int          mWp;
  logic [31:0] mRtime[NS];
  logic [15:0] mCnt[NS];
  logic [1:0]  mMode[NS];
  bit          mPrev[NS];
  logic [31:0] mTotal;
  bit          mHalt, mValid;
  int          mRdId;
  logic [31:0] mRdTaken, mRdRaised, mRdLat, mRdGap;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < D; i++) begin mTaken[i] = 0; mRaised[i] = 0; mId[i] = 0; end
      for (int s = 0; s < NS; s++) begin mRtime[s] = 0; mCnt[s] = 0; mMode[s] = 0; mPrev[s] = 0; end
      mWp = 0; mTotal = 0; mHalt = 0; mValid = 0; mRdId = 0;
      mRdTaken = 0; mRdRaised = 0; mRdLat = 0; mRdGap = 0;
    end else begin
      bit rise[NS];
      bit nHalt;
      nHalt = 0;
      for (int s = 0; s < NS; s++) begin
        rise[s] = pendVec[s] && !mPrev[s];
        if (rise[s] && mMode[s][0]) nHalt = 1;
      end
      if (takeValid && mMode[takeId][1]) nHalt = 1;
      if (rdEn) begin
        int sc, sn;
        sc = mWp - int'(rdIdx) - 1; if (sc < 0) sc += D;
        sn = mWp - int'(rdIdx);     if (sn < 0) sn += D;
        if (mTaken[sc] != 0) begin
          mValid = 1; mRdId = mId[sc]; mRdTaken = mTaken[sc];
          mRdRaised = mRaised[sc]; mRdLat = mTaken[sc] - mRaised[sc];
          mRdGap = (rdIdx == 0) ? 32'd0 : mTaken[sn] - mTaken[sc];
        end else begin
          mValid = 0; mRdId = 0; mRdTaken = 0; mRdRaised = 0; mRdLat = 0; mRdGap = 0;
        end
      end
      if (takeValid) begin
        mId[mWp] = int'(takeId);
        mTaken[mWp] = cyc;
        mRaised[mWp] = rise[takeId] ? cyc : mRtime[takeId];
        mWp = (mWp + 1) % D;
      end
      for (int s = 0; s < NS; s++) if (rise[s]) begin mRtime[s] = cyc; mCnt[s] = mCnt[s] + 1; end
      mTotal = mTotal + (takeValid ? 1 : 0) + (directRaise ? 1 : 0);
      if (modeWe) mMode[modeSrc] = modeVal;
      for (int s = 0; s < NS; s++) mPrev[s] = pendVec[s];
      mHalt = nHalt;
    end
  end

  task automatic chk(string tag, longint act, longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare every output against the model on every clock
  always @(negedge clk) begin
    chk("R5 rdValid", rdValid, mValid);
    chk("R2 rdId", rdId, mRdId);
    chk("R2 rdTaken", rdTaken, mRdTaken);
    chk("R1 rdRaised", rdRaised, mRdRaised);
    chk("R6 rdLatency", rdLatency, mRdLat);
    chk("R7 rdGap", rdGap, mRdGap);
    chk("R8 cntOut", cntOut, mCnt[cntSel]);
    chk("R9 totalRaised", totalRaised, mTotal);
    chk("R10 haltReq", haltReq, mHalt);
  end

  task automatic tick();
    @(posedge clk); #2;
    takeValid = 0; directRaise = 0; modeWe = 0; rdEn = 0;
  endtask

  task automatic setMode(int src, int val);
    modeWe = 1; modeSrc = 3'(src); modeVal = 2'(val); tick();
  endtask

  task automatic readAt(int idx);
    rdEn = 1; rdIdx = 4'(idx); tick();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [31:0] lfsr;
    logic [31:0] heldTaken;
    lfsr = 32'hACE1_1234;
    repeat (3) @(posedge clk);
    #2 rstN = 1;
    // R8: after reset, index 0 is empty and counters are zero
    readAt(0);
    @(negedge clk);
    chk("R8 reset rdValid", rdValid, 0);
    chk("R8 reset total", totalRaised, 0);
    chk("R5 empty rdTaken", rdTaken, 0);
    tick();
    setMode(2, 1); setMode(5, 2); setMode(7, 3);
    // R1/R10: raise source 2 (halt on raise)
    pendVec[2] = 1; cntSel = 3'd2; tick();
    @(negedge clk);
    chk("R10 halt on raise", haltReq, 1);
    chk("R1 count src2", cntOut, 1);
    tick();
    pendVec[5] = 1; tick(); tick(); tick();
    takeValid = 1; takeId = 3'd2; tick();
    takeValid = 1; takeId = 3'd5; tick();
    @(negedge clk);
    chk("R10 halt on take", haltReq, 1);
    directRaise = 1; takeValid = 1; takeId = 3'd5; tick();
    @(negedge clk);
    chk("R9 take+direct", totalRaised, mTotal);
    pendVec = '0; tick();
    // R11: source 7 rises and is taken in the same cycle
    pendVec[7] = 1; takeValid = 1; takeId = 3'd7; tick();
    readAt(0);
    @(negedge clk);
    chk("R11 same-cycle latency", rdLatency, 0);
    chk("R11 same-cycle id", rdId, 7);
    chk("R7 gap index0", rdGap, 0);
    for (int i = 0; i < 6; i++) readAt(i);
    // R4: outputs hold while rdEn is low, even across takes
    readAt(1);
    @(negedge clk);
    heldTaken = rdTaken;
    takeValid = 1; takeId = 3'd1; tick();
    takeValid = 1; takeId = 3'd3; tick();
    @(negedge clk);
    chk("R4 hold rdTaken", rdTaken, heldTaken);
    // Pseudo-random traffic
    for (int n = 0; n < 300; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      pendVec     = lfsr[7:0] & lfsr[15:8];
      takeValid   = lfsr[16];
      takeId      = lfsr[19:17];
      directRaise = lfsr[20] & lfsr[21];
      rdEn        = lfsr[22];
      rdIdx       = lfsr[26:23];
      cntSel      = lfsr[29:27];
      modeWe      = lfsr[30] & lfsr[31] & lfsr[5];
      modeSrc     = lfsr[2:0];
      modeVal     = lfsr[4:3];
      tick();
    end
    // R3: more than DEPTH takes, then the oldest slot holds a recent record
    pendVec = '0;
    for (int n = 0; n < D + 3; n++) begin takeValid = 1; takeId = 3'(n % NS); tick(); end
    readAt(D - 1);
    @(negedge clk);
    chk("R3 wrapped oldest valid", rdValid, 1);
    chk("R3 wrapped oldest id", rdId, 3 % NS);
    for (int i = 0; i < D; i++) readAt(i);
    tick();
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule